// File: doc/BRIEF.md
# Memory Domain Access Checker

This block makes the domain-level decision for every memory access that leaves address translation. It holds one 32-bit control word that splits into sixteen 2-bit fields, one per domain. Each field puts its domain into one of three classes: no access, client or manager. A manager domain lets every access through. A no-access domain aborts every access. A client domain lets the access through only when the page permission code, together with the system and ROM protection bits, allows it.

Each access brings the 4-bit domain number and the 2-bit permission code of the translation entry it hit. It also brings the privilege level, the access direction and the two protection bits. One clock later the block returns a registered verdict: grant, domain fault or permission fault. A separate write port loads the control word. Any mix of classes across the sixteen domains is allowed.

Top module: `mem_domain_guard`

## Requirements
- R1: After reset the control word is zero, so every domain is no-access, and all response outputs are low until a request arrives.
- R2: The class of domain n comes from control bits [2n+1:2n], selected by the request's domain number. Each field is decoded on its own, without regard to the other fields.
- R3: Field value 00 (no access) and field value 10 (reserved) abort the access with a domain fault, whatever the permission code, privilege, direction, S and R are.
- R4: Field value 11 (manager) grants the access, whatever the permission code, privilege, direction, S and R are.
- R5: Field value 01 (client) with permission code 11 grants reads and writes in both privileged and user mode.
- R6: Client with permission code 01 grants privileged reads and writes and denies all user accesses.
- R7: Client with permission code 10 grants privileged reads and writes and user reads, and denies user writes.
- R8: Client with permission code 00 grants only privileged reads when S=1 and R=0. It grants reads in both modes and no writes when S=0 and R=1. It denies everything when S equals R.
- R9: A client access that R5 to R8 deny returns a permission fault, never a domain fault.
- R10: A request sampled with req_valid_i high produces rsp_valid_o high on the next cycle, with exactly one of grant, domain fault and permission fault set. With no request, all four outputs are low.
- R11: A control write is used by requests presented in the cycle after the write. A request presented in the same cycle as the write still sees the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Load the control word |
| cfg_wdata_i | input | 32 | New control word, 2 bits per domain |
| req_valid_i | input | 1 | Access request present |
| req_dom_i | input | 4 | Domain number from the translation entry |
| req_perm_i | input | 2 | Permission code from the translation entry |
| req_priv_i | input | 1 | 1 = privileged access, 0 = user |
| req_write_i | input | 1 | 1 = write, 0 = read |
| prot_sys_i | input | 1 | System protection bit S |
| prot_rom_i | input | 1 | ROM protection bit R |
| rsp_valid_o | output | 1 | Verdict present |
| rsp_grant_o | output | 1 | Access may proceed |
| rsp_dom_fault_o | output | 1 | Abort: domain has no access |
| rsp_perm_fault_o | output | 1 | Abort: client permission check failed |

## Verification
The assertions assume every request input is a known value while req_valid_i is high. They also assume a response is checked only on the cycle after its request. The request attributes may be anything at all, so the checks must hold for every combination of domain, code, privilege, direction and protection bits. The bench drives all inputs on the falling edge and returns them to idle between requests. It sweeps the full client permission space and toggles every field class across the sixteen domains. It also places a control write in the same cycle as a request, to exercise the boundary at which the new word takes effect.

// File: rtl/mdg_pkg.sv
package mdg_pkg;
  localparam int unsigned FIELD_W = 2;

  typedef enum logic [1:0] {
    DOM_NONE   = 2'b00,
    DOM_CLIENT = 2'b01,
    DOM_RSVD   = 2'b10,
    DOM_MGR    = 2'b11
  } dom_mode_e;

  typedef enum logic [1:0] {
    AP_PROT  = 2'b00,
    AP_PRIV  = 2'b01,
    AP_UREAD = 2'b10,
    AP_FULL  = 2'b11
  } ap_code_e;

  typedef struct packed {
    logic grant;
    logic dom_fault;
    logic perm_fault;
  } verdict_t;
endpackage

// File: rtl/mdg_ctl_reg.sv
module mdg_ctl_reg #(
  parameter int unsigned CTL_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  output logic [CTL_W-1:0] ctl_o
);
  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_q <= '0;
    else if (we_i) ctl_q <= wdata_i;
  end

  assign ctl_o = ctl_q;

  assert_write_lands_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ctl_q == $past(wdata_i));
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctl_q));
endmodule

// File: rtl/mdg_dom_sel.sv
module mdg_dom_sel
  import mdg_pkg::*;
#(
  parameter int unsigned NUM_DOM = 16,
  localparam int unsigned CTL_W  = NUM_DOM * FIELD_W,
  localparam int unsigned IDX_W  = $clog2(NUM_DOM)
) (
  input  logic [CTL_W-1:0] ctl_i,
  input  logic [IDX_W-1:0] dom_i,
  output dom_mode_e        mode_o
);
  logic [FIELD_W-1:0] field [NUM_DOM];

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_field
    assign field[g] = ctl_i[g*FIELD_W +: FIELD_W];
  end

  assign mode_o = dom_mode_e'(field[dom_i]);
endmodule

// File: rtl/mdg_perm_chk.sv
module mdg_perm_chk
  import mdg_pkg::*;
(
  input  logic [1:0] ap_i,
  input  logic       priv_i,
  input  logic       write_i,
  input  logic       sys_i,
  input  logic       rom_i,
  output logic       allow_o
);
  always_comb begin
    unique case (ap_code_e'(ap_i))
      AP_FULL:  allow_o = 1'b1;
      AP_PRIV:  allow_o = priv_i;
      AP_UREAD: allow_o = priv_i | ~write_i;
      AP_PROT: begin
        // S and R pick the read-only flavour; equal bits deny
        unique case ({sys_i, rom_i})
          2'b10:   allow_o = priv_i & ~write_i;
          2'b01:   allow_o = ~write_i;
          default: allow_o = 1'b0;
        endcase
      end
      default:  allow_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mem_domain_guard.sv
module mem_domain_guard
  import mdg_pkg::*;
#(
  parameter int unsigned NUM_DOM = 16,
  localparam int unsigned CTL_W  = NUM_DOM * FIELD_W,
  localparam int unsigned IDX_W  = $clog2(NUM_DOM)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CTL_W-1:0] cfg_wdata_i,
  input  logic             req_valid_i,
  input  logic [IDX_W-1:0] req_dom_i,
  input  logic [1:0]       req_perm_i,
  input  logic             req_priv_i,
  input  logic             req_write_i,
  input  logic             prot_sys_i,
  input  logic             prot_rom_i,
  output logic             rsp_valid_o,
  output logic             rsp_grant_o,
  output logic             rsp_dom_fault_o,
  output logic             rsp_perm_fault_o
);
  logic [CTL_W-1:0] ctl;
  dom_mode_e        mode;
  logic             allow;
  verdict_t         verdict_d, verdict_q;
  logic             valid_q;

  mdg_ctl_reg #(.CTL_W(CTL_W)) u_ctl (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .wdata_i(cfg_wdata_i), .ctl_o(ctl)
  );

  mdg_dom_sel #(.NUM_DOM(NUM_DOM)) u_sel (
    .ctl_i(ctl), .dom_i(req_dom_i), .mode_o(mode)
  );

  mdg_perm_chk u_perm (
    .ap_i(req_perm_i), .priv_i(req_priv_i), .write_i(req_write_i),
    .sys_i(prot_sys_i), .rom_i(prot_rom_i), .allow_o(allow)
  );

  always_comb begin
    verdict_d = '0;
    unique case (mode)
      DOM_MGR:    verdict_d.grant = 1'b1;
      DOM_CLIENT: begin
        verdict_d.grant      = allow;
        verdict_d.perm_fault = ~allow;
      end
      default:    verdict_d.dom_fault = 1'b1; // none and reserved
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      verdict_q <= '0;
    end else begin
      valid_q   <= req_valid_i;
      verdict_q <= req_valid_i ? verdict_d : '0;
    end
  end

  assign rsp_valid_o      = valid_q;
  assign rsp_grant_o      = verdict_q.grant;
  assign rsp_dom_fault_o  = verdict_q.dom_fault;
  assign rsp_perm_fault_o = verdict_q.perm_fault;

  assert_rsp_follows_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  assert_rsp_has_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_valid_i));
  assert_one_verdict_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones({rsp_grant_o, rsp_dom_fault_o, rsp_perm_fault_o}) == 1);
  assert_quiet_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !(rsp_grant_o || rsp_dom_fault_o || rsp_perm_fault_o));
  assert_mgr_grant_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode == DOM_MGR) |=> rsp_grant_o);
  assert_noacc_fault_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (mode == DOM_NONE || mode == DOM_RSVD)) |=> rsp_dom_fault_o);
  assert_perm_fault_client_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_perm_fault_o |-> $past(mode) == DOM_CLIENT);
endmodule

// File: tb/tb_mem_domain_guard.sv
module tb_mem_domain_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_dom = '0;
  logic [1:0]  req_perm = '0;
  logic        req_priv = 1'b0, req_write = 1'b0, prot_sys = 1'b0, prot_rom = 1'b0;
  logic        rsp_valid, rsp_grant, rsp_dom_fault, rsp_perm_fault;

  int checks = 0;
  int errors = 0;
  logic [31:0] shadow = '0;

  always #4 clk = ~clk;

  mem_domain_guard dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .req_valid_i(req_valid), .req_dom_i(req_dom), .req_perm_i(req_perm),
    .req_priv_i(req_priv), .req_write_i(req_write), .prot_sys_i(prot_sys),
    .prot_rom_i(prot_rom), .rsp_valid_o(rsp_valid), .rsp_grant_o(rsp_grant),
    .rsp_dom_fault_o(rsp_dom_fault), .rsp_perm_fault_o(rsp_perm_fault)
  );

  // {valid, grant, dom_fault, perm_fault}
  function automatic logic [3:0] expect_rsp(logic [31:0] w, int d, int ap,
                                            bit pv, bit wr, bit s, bit r);
    logic [1:0] f = w[2*d +: 2];
    bit ok;
    if (f == 2'b11) return 4'b1100;
    if (f != 2'b01) return 4'b1010;
    case (ap)
      3: ok = 1;
      1: ok = pv;
      2: ok = pv || !wr;
      default: ok = (s && !r) ? (pv && !wr) : (!s && r) ? !wr : 0;
    endcase
    return ok ? 4'b1100 : 4'b1001;
  endfunction

  task automatic check(string tag, logic [3:0] exp);
    logic [3:0] act = {rsp_valid, rsp_grant, rsp_dom_fault, rsp_perm_fault};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic write_ctl(logic [31:0] w);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    shadow = w;
  endtask

  task automatic access(string tag, int d, int ap, bit pv, bit wr, bit s, bit r);
    req_valid = 1'b1; req_dom = 4'(d); req_perm = 2'(ap);
    req_priv = pv; req_write = wr; prot_sys = s; prot_rom = r;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, expect_rsp(shadow, d, ap, pv, wr, s, r));
  endtask

  task automatic t_reset;
    check("R1 outputs after reset", 4'b0000);
    for (int d = 0; d < 16; d += 5) access("R1 zero word gives domain fault", d, 3, 1, 0, 0, 0);
  endtask

  task automatic t_idle;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10 idle outputs low", 4'b0000);
    end
  endtask

  task automatic t_field_map;
    logic [31:0] w = '0;
    for (int d = 0; d < 16; d++) w[2*d +: 2] = 2'(d % 4);
    write_ctl(w);
    for (int d = 0; d < 16; d++) access("R2 per-domain field", d, 0, 1, 0, 0, 0);
    write_ctl(~w);
    for (int d = 0; d < 16; d++) access("R2 inverted fields", d, 0, 1, 0, 0, 0);
  endtask

  task automatic t_noaccess;
    write_ctl(32'h0000_AAAA);
    for (int c = 0; c < 64; c++)
      access("R3 no-access and reserved", (c % 2) ? 3 : 12, c % 4, c[2], c[3], c[4], c[5]);
  endtask

  task automatic t_manager;
    write_ctl(32'hFFFF_FFFF);
    for (int c = 0; c < 64; c++)
      access("R4 manager ignores code", c % 16, c % 4, c[2], c[3], c[4], c[5]);
  endtask

  task automatic t_client;
    write_ctl(32'h5555_5555);
    for (int c = 0; c < 64; c++) begin
      int ap = c % 4;
      string tag;
      case (ap)
        3: tag = "R5 client full";
        1: tag = "R6 client privileged only";
        2: tag = "R7 client user read";
        default: tag = "R8 client S/R";
      endcase
      tag = {tag, " / R9 fault kind"};
      access(tag, 9, ap, c[2], c[3], c[4], c[5]);
    end
  endtask

  task automatic t_write_timing;
    write_ctl(32'h0);
    // request in the write cycle sees old word
    cfg_we = 1'b1; cfg_wdata = 32'hFFFF_FFFF;
    req_valid = 1'b1; req_dom = 4'd6; req_perm = 2'd0;
    req_priv = 1'b0; req_write = 1'b1; prot_sys = 1'b0; prot_rom = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R11 same-cycle request uses old word", 4'b1010);
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 next-cycle request uses new word", 4'b1100);
    shadow = 32'hFFFF_FFFF;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_field_map();
    t_noaccess();
    t_manager();
    t_client();
    t_write_timing();
    t_idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule